// File: doc/BRIEF.md
# Bus Talker Source Handshake Controller

This block is the sending end of a three-wire byte handshake on a parallel instrument bus. It watches command bytes presented with a strobe. When a byte in the talk-address group carries this device's own address, the block becomes the active talker. It then drives the bus data lines from a byte latch that the host processor loads.

While talking, the block raises data-valid for the listeners once three things are true: the listener reports ready, the host says a fresh byte is available, and serial-poll mode is not selected. The block drops data-valid when the listener reports acceptance.

A talk-handshake status flag tells the host when a transfer is pending and when it has completed. The host answers completion by withdrawing its new-byte flag. A further byte can go out only after the host raises that flag again. Both listener lines are asynchronous, so each passes through a two-flop synchronizer before the block acts on it.

Top module: `bus_talker_src`

## Requirements
- R1: When `cmd_stb` is high and `cmd_byte[6:5]` equals 2'b10 with `cmd_byte[4:0]` equal to `DEV_ADDR`, the talk state is entered at that clock edge, so `den` and `ths` are high from the following cycle. Bit 7 is ignored.
- R2: A strobed talk-group command (`cmd_byte[6:5]` = 2'b10) with any other address leaves talk state at that edge, and this includes the untalk value 5'h1F. `den`, `dav` and `ths` are all low from the next cycle. Commands in any other group have no effect.
- R3: `ths` is high while talking and a byte is pending or being offered. `ths` is never low while `dav` is high.
- R4: `dav` rises only at an edge where the synchronized ready line, `host_nba` and talk state are all high and `spoll_sel` is low.
- R5: At an edge where `dav` is high and the synchronized accepted line is high, `dav` and `ths` both go low.
- R6: After an acceptance, `ths` and `dav` stay low while `host_nba` stays high. `ths` rises again at the first edge that sees `host_nba` low. `dav` can only follow after `host_nba` is high again.
- R7: `host_wr` loads `host_data` into the output latch at the clock edge. `bus_data` equals the latch while `den` is high and `spoll_act` is low, and is zero otherwise.
- R8: A change on `lsn_rdy` or `lsn_acc` takes effect on `dav` at the third clock edge after the change (two synchronizer stages plus the state register).
- R9: While `rst` is high, the talk state, handshake state, synchronizers and latch are cleared at each edge. The next cycle shows `den`, `dav` and `ths` low and `bus_data` zero.
- R10: If `host_nba` falls or `spoll_sel` rises while `dav` is high and no acceptance is seen, `dav` falls at that edge and `ths` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_byte | input | 8 | Bus command byte |
| cmd_stb | input | 1 | Command byte valid strobe |
| host_data | input | DATA_W | Byte written by the host |
| host_wr | input | 1 | Host write strobe for the output latch |
| host_nba | input | 1 | Host flag: new byte available |
| spoll_sel | input | 1 | Serial-poll mode select; blocks data-valid |
| spoll_act | input | 1 | Serial-poll active; blocks the data latch |
| lsn_rdy | input | 1 | Listener ready for data, asynchronous |
| lsn_acc | input | 1 | Listener data accepted, asynchronous |
| den | output | 1 | Data enable for the outward bus drivers |
| dav | output | 1 | Data valid toward the listeners |
| ths | output | 1 | Talk-handshake status flag for the host |
| bus_data | output | DATA_W | Data driven onto the bus lines |

## Verification
The handshake is driven through a full byte cycle, and then through variants that each isolate one gating term. Ready is held off, then serial-poll select is held on, then the new-byte flag is withdrawn while data-valid is up. Each variant shows a different term blocking or withdrawing data-valid.

Holding the new-byte flag high after acceptance separates a correct design from one that would resend the byte. A ready edge is timed against the clock, which shows whether the synchronizer depth is right. Foreign talk addresses, untalk, listen-group commands and a mid-cycle reset show that leaving talk state clears every output at once, while the wrong command group changes nothing.

// File: rtl/bts_pkg.sv
package bts_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WAIT  = 2'd1,
        PH_VALID = 2'd2,
        PH_DONE  = 2'd3
    } src_phase_e;

    typedef struct packed {
        logic       spare;
        logic [1:0] grp;
        logic [4:0] addr;
    } cmd_fields_t;

    typedef struct packed {
        logic rdy;
        logic acc;
    } lsn_lines_t;

    localparam logic [1:0] GRP_TALK = 2'b10;
    localparam int         CMD_W    = 8;
    localparam int         ADDR_W   = 5;

    function automatic cmd_fields_t split_cmd(input logic [CMD_W-1:0] b);
        return cmd_fields_t'(b);
    endfunction

    function automatic logic phase_has_ths(input src_phase_e p);
        return (p == PH_WAIT) || (p == PH_VALID);
    endfunction

endpackage

// File: rtl/bts_sync.sv
module bts_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= {st[STAGES-2:0], d};
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/bts_talk_decode.sv
module bts_talk_decode
    import bts_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 5'd7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_stb,
    input  logic [CMD_W-1:0] cmd_byte,
    output logic             talk_q,
    output logic             talk_nxt
);
    cmd_fields_t f;

    always_comb begin
        f        = split_cmd(cmd_byte);
        talk_nxt = talk_q;
        if (cmd_stb && (f.grp == GRP_TALK)) begin
            talk_nxt = (f.addr == DEV_ADDR);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            talk_q <= 1'b0;
        end else begin
            talk_q <= talk_nxt;
        end
    end
endmodule

// File: rtl/bts_src_fsm.sv
module bts_src_fsm
    import bts_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic talk_nxt,
    input  logic rdy_s,
    input  logic acc_s,
    input  logic nba,
    input  logic spoll_sel,
    output logic dav,
    output logic ths
);
    src_phase_e ph_q, ph_d;

    always_comb begin
        ph_d = ph_q;
        if (!talk_nxt) begin
            ph_d = PH_IDLE;
        end else begin
            unique case (ph_q)
                PH_IDLE:  ph_d = PH_WAIT;
                PH_WAIT:  if (rdy_s && nba && !spoll_sel) ph_d = PH_VALID;
                PH_VALID: begin
                    if (acc_s)                 ph_d = PH_DONE;
                    else if (!nba || spoll_sel) ph_d = PH_WAIT;
                end
                PH_DONE:  if (!nba) ph_d = PH_WAIT;
                default:  ph_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign dav = (ph_q == PH_VALID);
    assign ths = phase_has_ths(ph_q);
endmodule

// File: rtl/bts_out_latch.sv
module bts_out_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              den,
    input  logic              spoll_act,
    output logic [DATA_W-1:0] bus_data
);
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (wr) begin
            hold_q <= wdata;
        end
    end

    assign bus_data = (den && !spoll_act) ? hold_q : '0;
endmodule

// File: rtl/bus_talker_src.sv
module bus_talker_src
    import bts_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 5'd7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CMD_W-1:0]  cmd_byte,
    input  logic              cmd_stb,
    input  logic [DATA_W-1:0] host_data,
    input  logic              host_wr,
    input  logic              host_nba,
    input  logic              spoll_sel,
    input  logic              spoll_act,
    input  logic              lsn_rdy,
    input  logic              lsn_acc,
    output logic              den,
    output logic              dav,
    output logic              ths,
    output logic [DATA_W-1:0] bus_data
);
    localparam int LW = $bits(lsn_lines_t);

    lsn_lines_t raw_l, syn_l;
    logic       talk_q, talk_nxt;
    logic       rdy_s, acc_s;

    assign raw_l.rdy = lsn_rdy;
    assign raw_l.acc = lsn_acc;

    bts_sync #(.W(LW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_l),
        .q   (syn_l)
    );

    assign rdy_s = syn_l.rdy;
    assign acc_s = syn_l.acc;

    bts_talk_decode #(.DEV_ADDR(DEV_ADDR)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .cmd_stb  (cmd_stb),
        .cmd_byte (cmd_byte),
        .talk_q   (talk_q),
        .talk_nxt (talk_nxt)
    );

    assign den = talk_q;

    bts_src_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .talk_nxt  (talk_nxt),
        .rdy_s     (rdy_s),
        .acc_s     (acc_s),
        .nba       (host_nba),
        .spoll_sel (spoll_sel),
        .dav       (dav),
        .ths       (ths)
    );

    bts_out_latch #(.DATA_W(DATA_W)) u_lat (
        .clk       (clk),
        .rst       (rst),
        .wr        (host_wr),
        .wdata     (host_data),
        .den       (talk_q),
        .spoll_act (spoll_act),
        .bus_data  (bus_data)
    );
endmodule

// File: rtl/bts_checker.sv
module bts_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              den,
    input logic              dav,
    input logic              ths,
    input logic [DATA_W-1:0] bus_data,
    input logic              spoll_act,
    input logic              spoll_sel,
    input logic              host_nba,
    input logic              rdy_s,
    input logic              acc_s
);
    a_r9_reset_idle: assert property (@(posedge clk)
        rst |=> (!dav && !den && !ths && bus_data == '0));

    a_r4_dav_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(dav) |-> $past(rdy_s && host_nba && !spoll_sel));

    a_r2_dav_needs_den: assert property (@(posedge clk) disable iff (rst)
        dav |-> den);

    a_r3_ths_with_dav: assert property (@(posedge clk) disable iff (rst)
        dav |-> ths);

    a_r5_accept_clears: assert property (@(posedge clk) disable iff (rst)
        (dav && acc_s) |=> (!dav && !ths));

    a_r6_no_resend: assert property (@(posedge clk) disable iff (rst)
        ($rose(ths) && $past(den)) |-> $past(!host_nba));

    a_r7_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        (!den || spoll_act) |-> (bus_data == '0));
endmodule

bind bus_talker_src bts_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .den       (den),
    .dav       (dav),
    .ths       (ths),
    .bus_data  (bus_data),
    .spoll_act (spoll_act),
    .spoll_sel (spoll_sel),
    .host_nba  (host_nba),
    .rdy_s     (rdy_s),
    .acc_s     (acc_s)
);

// File: tb/tb_bus_talker_src.sv
module tb_bus_talker_src;
    localparam logic [4:0] ADDR = 5'd7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cmd_byte = '0;
    logic       cmd_stb = 1'b0;
    logic [7:0] host_data = '0;
    logic       host_wr = 1'b0;
    logic       host_nba = 1'b0;
    logic       spoll_sel = 1'b0;
    logic       spoll_act = 1'b0;
    logic       lsn_rdy = 1'b0;
    logic       lsn_acc = 1'b0;
    logic       den, dav, ths;
    logic [7:0] bus_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    bus_talker_src #(.DATA_W(8), .SYNC_STAGES(2), .DEV_ADDR(ADDR)) dut (
        .clk(clk), .rst(rst), .cmd_byte(cmd_byte), .cmd_stb(cmd_stb),
        .host_data(host_data), .host_wr(host_wr), .host_nba(host_nba),
        .spoll_sel(spoll_sel), .spoll_act(spoll_act),
        .lsn_rdy(lsn_rdy), .lsn_acc(lsn_acc),
        .den(den), .dav(dav), .ths(ths), .bus_data(bus_data)
    );

    // Behavioural reference: queues model the synchronizer delay.
    bit m_talk = 0;
    int m_phase = 0; // 0 off, 1 pending, 2 offering, 3 accepted
    logic [7:0] m_latch = '0;
    bit rdy_q[$] = '{0, 0};
    bit acc_q[$] = '{0, 0};

    always @(posedge clk) begin
        bit r2, a2, t_n;
        r2 = rdy_q[0];
        a2 = acc_q[0];
        if (rst) begin
            m_talk = 0; m_phase = 0; m_latch = '0;
            rdy_q = '{0, 0}; acc_q = '{0, 0};
        end else begin
            t_n = m_talk;
            if (cmd_stb && cmd_byte[6:5] == 2'b10) t_n = (cmd_byte[4:0] == ADDR);
            if (!t_n) m_phase = 0;
            else if (m_phase == 0) m_phase = 1;
            else if (m_phase == 1) begin
                if (r2 && host_nba && !spoll_sel) m_phase = 2;
            end else if (m_phase == 2) begin
                if (a2) m_phase = 3;
                else if (!host_nba || spoll_sel) m_phase = 1;
            end else if (!host_nba) m_phase = 1;
            m_talk = t_n;
            if (host_wr) m_latch = host_data;
            void'(rdy_q.pop_front()); rdy_q.push_back(lsn_rdy);
            void'(acc_q.pop_front()); acc_q.push_back(lsn_acc);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk(den == m_talk, "R1/R2 den", den, m_talk);
            chk(dav == (m_phase == 2), "R4 dav", dav, m_phase == 2);
            chk(ths == (m_phase == 1 || m_phase == 2), "R3 ths", ths, m_phase == 1 || m_phase == 2);
            chk(bus_data == ((m_talk && !spoll_act) ? m_latch : 8'h00), "R7 bus_data",
                bus_data, (m_talk && !spoll_act) ? m_latch : 8'h00);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic send_cmd(input logic [7:0] b);
        cmd_byte = b; cmd_stb = 1'b1;
        step(1);
        cmd_stb = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b);
        host_data = b; host_wr = 1'b1;
        step(1);
        host_wr = 1'b0;
    endtask

    initial begin
        step(3);
        chk(!den && !dav && !ths && bus_data == 0, "R9 reset", {den, dav, ths}, 0);
        rst = 1'b0;
        step(1);
        write_byte(8'hA5);
        chk(bus_data == 8'h00, "R7 idle quiet", bus_data, 0);
        send_cmd(8'h27);                         // listen group, own address
        step(1);
        chk(!den, "R2 listen group ignored", den, 0);
        send_cmd(8'hC7);                         // bit 7 set, talk group, own address
        chk(den && ths && !dav, "R1 talk entered", {den, ths, dav}, 3'b110);
        chk(bus_data == 8'hA5, "R7 latch driven", bus_data, 8'hA5);
        spoll_act = 1'b1; step(1);
        chk(bus_data == 8'h00, "R7 spoll_act blocks", bus_data, 0);
        spoll_act = 1'b0;
        host_nba = 1'b1; step(5);
        chk(!dav, "R4 no ready", dav, 0);
        spoll_sel = 1'b1; lsn_rdy = 1'b1; step(5);
        chk(!dav, "R4 spoll_sel blocks", dav, 0);
        spoll_sel = 1'b0; step(1);
        chk(dav && ths, "R4 dav raised", {dav, ths}, 2'b11);
        lsn_acc = 1'b1; lsn_rdy = 1'b0; step(2);
        chk(dav, "R8 accept not yet seen", dav, 1);
        step(1);
        chk(!dav && !ths, "R5 accept clears", {dav, ths}, 0);
        lsn_acc = 1'b0; step(6);
        chk(!dav && !ths, "R6 no resend while nba high", {dav, ths}, 0);
        host_nba = 1'b0; step(1);
        chk(ths && !dav, "R6 ths back after nba low", {ths, dav}, 2'b10);
        write_byte(8'h3C);
        host_nba = 1'b1; step(4);
        chk(!dav, "R4 waiting ready", dav, 0);
        lsn_rdy = 1'b1; step(2);
        chk(!dav, "R8 two edges", dav, 0);
        step(1);
        chk(dav && bus_data == 8'h3C, "R8 third edge", {dav, bus_data}, {1'b1, 8'h3C});
        host_nba = 1'b0; step(1);
        chk(!dav && ths, "R10 nba withdraw", {dav, ths}, 2'b01);
        host_nba = 1'b1; step(1);
        chk(dav, "R10 reoffer", dav, 1);
        spoll_sel = 1'b1; step(1);
        chk(!dav && ths, "R10 spoll_sel withdraw", {dav, ths}, 2'b01);
        spoll_sel = 1'b0; step(2);
        send_cmd(8'h48);                         // another device talks
        chk(!den && !dav && !ths, "R2 foreign talk", {den, dav, ths}, 0);
        send_cmd(8'h47); step(2);
        chk(dav, "R1 talk again offers", dav, 1);
        send_cmd(8'h5F);                         // untalk
        chk(!den && !dav && !ths && bus_data == 0, "R2 untalk", {den, dav, ths}, 0);
        send_cmd(8'h47); step(3);
        rst = 1'b1; step(1);
        chk(!den && !dav && !ths && bus_data == 0, "R9 reset mid-talk", {den, dav, ths}, 0);
        rst = 1'b0; send_cmd(8'h47);
        chk(bus_data == 8'h00, "R9 latch cleared", bus_data, 0);
        step(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule